// File: doc/BRIEF.md
# Dummy-Byte Injecting Write Snooper

This block sits between a host that drives a serial flash bus one byte group at a time and the byte-transfer side of that bus. Every host write of one to four bytes is forwarded to the bus as consecutive bytes, lowest byte first. When the host opens a transfer by selecting the device, the block watches the first byte as a command opcode. It looks up how many dummy bytes that command needs, and it counts the bytes that follow for the address phase.

When the count shows that the address phase is over, the host's next write is not forwarded. The block sends the whole run of dummy bytes itself, each one equal to a configured fill value. It then stops watching until the next select. This lets software that has no notion of dummy cycles still drive fast-read style commands correctly.

A release of the device ends the transfer and discards any pending dummy count. Select and release requests are taken only while no byte run is being sent.

Top module: `spi_dummy_snooper`

## Requirements
- R1: Out of reset `spi_cs_n` is 1, `spi_valid` is 0, `wr_ready` is 1 and watching is off, so the first writes pass through untouched.
- R2: A `cs_sel` pulse in an idle cycle drives `spi_cs_n` low from the next cycle and arms watching with the byte position at zero. A `cs_rel` pulse in an idle cycle drives it high, disarms watching and discards any pending dummy count. When both pulses arrive in the same cycle, release wins.
- R3: A write is accepted when `wr_valid` and `wr_ready` are both high. `wr_size` encodes the byte count minus one. A forwarded write of n bytes appears as n consecutive `spi_valid` cycles, starting the cycle after acceptance, with `wr_data[7:0]` first. `wr_ready` is low while bytes are sent and in any cycle that carries `cs_sel` or `cs_rel`.
- R4: While watching is off, every write is forwarded unchanged and no dummy byte is produced.
- R5: The first write after arming is forwarded, and its low byte is taken as the opcode. Opcodes 0x03, 0x02, 0xA2, 0x32, 0x13, 0x12, 0x34 need no dummy bytes and disarm watching. Any opcode outside the tables in R5 and R6 also disarms.
- R6: Dummy units per opcode: 0x0B, 0x3B, 0x6B, 0x3C and 0x6C need 1 unit; 0xBB, 0x0C and 0xBC need 2; 0xEB and 0xEC need 4. One unit is `DUMMY_SCALE` bytes (8 by default). The resulting count is stored as pending.
- R7: Each forwarded write while armed, the opcode write included, advances the byte position by its size. A write accepted when the position is already at least the address width plus one (4 with `addr4`=0, 5 with `addr4`=1) is dropped. In its place the block sends the pending count of fill bytes and then disarms.
- R8: `addr4` is sampled at each acceptance, so in 4-byte mode a write at position 4 is still forwarded.
- R9: Every injected byte equals the `dummy_val` sampled when the dropped write was accepted; later changes of `dummy_val` do not affect the run.
- R10: `cs_sel` and `cs_rel` pulses that arrive while bytes are being sent are ignored: `spi_cs_n` and the watching state are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_sel | input | 1 | Request to select the device (one-cycle pulse) |
| cs_rel | input | 1 | Request to release the device (one-cycle pulse) |
| addr4 | input | 1 | 1 when commands carry 4 address bytes, 0 for 3 |
| dummy_val | input | 8 | Byte value used for injected dummy bytes |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Host write can be accepted this cycle |
| wr_data | input | 8*MAX_WR_BYTES | Host write data, low byte sent first |
| wr_size | input | clog2(MAX_WR_BYTES) | Number of bytes in the write minus one |
| spi_cs_n | output | 1 | Device select, active low |
| spi_valid | output | 1 | A byte is on `spi_byte` this cycle |
| spi_byte | output | 8 | Byte sent to the bus |

## Verification
The bench builds the block with its defaults, MAX_WR_BYTES = 4 and DUMMY_SCALE = 8. With these values every write size from one to four bytes can be used, and the longest fill run of 32 bytes is reached. Each opcode of the two tables is run through the same select, opcode, address and trigger sequence. The 3-byte and 4-byte thresholds, multi-byte opcode writes, a release in the middle of a command and select or release pulses that land during a byte run are also covered.

// File: rtl/dsnoop_pkg.sv
package dsnoop_pkg;

  // Byte-position codes of the watcher
  localparam logic [7:0] POS_OFF   = 8'hFF;
  localparam logic [7:0] POS_START = 8'h00;

  // Largest dummy unit count of any known opcode
  localparam int unsigned MAX_UNITS = 4;

  // Position from which the next write is replaced by the fill run
  function automatic logic [7:0] fill_threshold(input logic wide_addr);
    return wide_addr ? 8'd5 : 8'd4;
  endfunction

  // Fill bytes owed for a unit count
  function automatic int unsigned fill_count(input logic [2:0] units,
                                             input int unsigned scale);
    return int'(units) * scale;
  endfunction

  // Byte position after forwarding n more bytes
  function automatic logic [7:0] advance_pos(input logic [7:0] pos,
                                             input int unsigned n);
    return 8'(int'(pos) + n);
  endfunction

endpackage

// File: rtl/dsnoop_opdecode.sv
module dsnoop_opdecode (
  input  logic [7:0] opcode,
  output logic [2:0] units
);
  always_comb begin
    unique case (opcode)
      8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = 3'd1;
      8'hBB, 8'h0C, 8'hBC:               units = 3'd2;
      8'hEB, 8'hEC:                      units = 3'd4;
      default:                           units = 3'd0;  // plain or unknown
    endcase
  end
endmodule

// File: rtl/dsnoop_tracker.sv
module dsnoop_tracker
  import dsnoop_pkg::*;
#(
  parameter int unsigned DUMMY_SCALE = 8,
  parameter int unsigned CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_take,
  input  logic             rel_take,
  input  logic             accept,
  input  logic             wide_addr,
  input  logic [CNT_W-1:0] wr_bytes,
  input  logic [2:0]       units,
  output logic             armed,
  output logic             opcode_phase,
  output logic             do_fill,
  output logic [CNT_W-1:0] fill_len
);
  logic [7:0]       pos_q;
  logic [CNT_W-1:0] pend_q;
  logic [7:0]       pos_step;

  assign armed        = (pos_q != POS_OFF);
  assign opcode_phase = (pos_q == POS_START);
  assign do_fill      = armed && !opcode_phase && (pos_q >= fill_threshold(wide_addr));
  assign fill_len     = pend_q;
  assign pos_step     = advance_pos(pos_q, int'(wr_bytes));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= POS_OFF;
      pend_q <= '0;
    end else if (rel_take) begin
      pos_q  <= POS_OFF;
      pend_q <= '0;
    end else if (sel_take) begin
      pos_q  <= POS_START;
      pend_q <= '0;
    end else if (accept && armed) begin
      if (opcode_phase) begin
        if (units == 3'd0) begin
          pos_q <= POS_OFF;
        end else begin
          pend_q <= CNT_W'(fill_count(units, DUMMY_SCALE));
          pos_q  <= pos_step;
        end
      end else if (do_fill) begin
        pos_q  <= POS_OFF;
        pend_q <= '0;
      end else begin
        pos_q <= pos_step;
      end
    end
  end
endmodule

// File: rtl/dsnoop_serializer.sv
module dsnoop_serializer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_fill,
  input  logic [CNT_W-1:0]  load_len,
  input  logic [DATA_W-1:0] load_data,
  input  logic [7:0]        fill_byte,
  output logic              busy,
  output logic              fill_active,
  output logic [7:0]        out_byte
);
  logic              busy_q;
  logic              fill_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] shf_q;
  logic [7:0]        fbyte_q;

  assign busy        = busy_q;
  assign fill_active = fill_q;
  assign out_byte    = fill_q ? fbyte_q : shf_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fill_q  <= 1'b0;
      left_q  <= '0;
      shf_q   <= '0;
      fbyte_q <= '0;
    end else if (load) begin
      busy_q  <= (load_len != '0);
      fill_q  <= load_fill;
      left_q  <= load_len;
      shf_q   <= load_data;
      fbyte_q <= fill_byte;
    end else if (busy_q) begin
      left_q <= left_q - CNT_W'(1);
      shf_q  <= shf_q >> 8;
      if (left_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        fill_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dummy_snooper.sv
module spi_dummy_snooper
  import dsnoop_pkg::*;
#(
  parameter int unsigned MAX_WR_BYTES = 4,
  parameter int unsigned DUMMY_SCALE  = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cs_sel,
  input  logic                                cs_rel,
  input  logic                                addr4,
  input  logic [7:0]                          dummy_val,
  input  logic                                wr_valid,
  output logic                                wr_ready,
  input  logic [8*MAX_WR_BYTES-1:0]           wr_data,
  input  logic [$clog2(MAX_WR_BYTES)-1:0]     wr_size,
  output logic                                spi_cs_n,
  output logic                                spi_valid,
  output logic [7:0]                          spi_byte
);
  localparam int unsigned DATA_W   = 8 * MAX_WR_BYTES;
  localparam int unsigned MAX_FILL = MAX_UNITS * DUMMY_SCALE;
  localparam int unsigned MAX_RUN  = (MAX_FILL > MAX_WR_BYTES) ? MAX_FILL : MAX_WR_BYTES;
  localparam int unsigned CNT_W    = $clog2(MAX_RUN + 1);

  // Named internal events
  logic             busy;
  logic             fill_active;
  logic             sel_take;
  logic             rel_take;
  logic             accept;
  logic             armed;
  logic             opcode_phase;
  logic             do_fill;
  logic [2:0]       op_units;
  logic [CNT_W-1:0] wr_bytes;
  logic [CNT_W-1:0] fill_len;
  logic [CNT_W-1:0] run_len;
  logic             cs_n_q;

  assign rel_take = cs_rel && !busy;
  assign sel_take = cs_sel && !cs_rel && !busy;
  assign wr_ready = !busy && !cs_sel && !cs_rel;
  assign accept   = wr_valid && wr_ready;
  assign wr_bytes = CNT_W'(wr_size) + CNT_W'(1);
  assign run_len  = do_fill ? fill_len : wr_bytes;

  dsnoop_opdecode u_dec (
    .opcode (wr_data[7:0]),
    .units  (op_units)
  );

  dsnoop_tracker #(
    .DUMMY_SCALE (DUMMY_SCALE),
    .CNT_W       (CNT_W)
  ) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_take     (sel_take),
    .rel_take     (rel_take),
    .accept       (accept),
    .wide_addr    (addr4),
    .wr_bytes     (wr_bytes),
    .units        (op_units),
    .armed        (armed),
    .opcode_phase (opcode_phase),
    .do_fill      (do_fill),
    .fill_len     (fill_len)
  );

  dsnoop_serializer #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_fill   (do_fill),
    .load_len    (run_len),
    .load_data   (wr_data),
    .fill_byte   (dummy_val),
    .busy        (busy),
    .fill_active (fill_active),
    .out_byte    (spi_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        cs_n_q <= 1'b1;
    else if (rel_take) cs_n_q <= 1'b1;
    else if (sel_take) cs_n_q <= 1'b0;
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_valid = busy;
endmodule

// File: rtl/spi_dummy_snooper_chk.sv
module spi_dummy_snooper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_sel,
  input logic       cs_rel,
  input logic       wr_ready,
  input logic [7:0] wr_byte0,
  input logic       spi_cs_n,
  input logic       spi_valid,
  input logic [7:0] spi_byte,
  input logic       busy,
  input logic       fill_active,
  input logic       sel_take,
  input logic       rel_take,
  input logic       accept,
  input logic       armed,
  input logic       opcode_phase,
  input logic       do_fill,
  input logic [2:0] op_units
);
  AST_SELECT_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel_take |=> !spi_cs_n); // R2
  AST_RELEASE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_take |=> (spi_cs_n && !armed)); // R2
  AST_ACCEPT_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> spi_valid); // R3
  AST_NO_READY_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    spi_valid |-> !wr_ready); // R3
  AST_OFF_PASSES_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !armed) |=> (spi_valid && !fill_active && spi_byte == $past(wr_byte0))); // R4
  AST_PLAIN_OPCODE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode_phase && op_units == 3'd0) |=> !armed); // R5
  AST_FILL_THEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && do_fill) |=> (!armed && fill_active)); // R7
  AST_FILL_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid && fill_active && $past(spi_valid && fill_active)) |-> $stable(spi_byte)); // R9
  AST_BUSY_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cs_sel || cs_rel)) |=> $stable(spi_cs_n)); // R10
endmodule

bind spi_dummy_snooper spi_dummy_snooper_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_sel       (cs_sel),
  .cs_rel       (cs_rel),
  .wr_ready     (wr_ready),
  .wr_byte0     (wr_data[7:0]),
  .spi_cs_n     (spi_cs_n),
  .spi_valid    (spi_valid),
  .spi_byte     (spi_byte),
  .busy         (busy),
  .fill_active  (fill_active),
  .sel_take     (sel_take),
  .rel_take     (rel_take),
  .accept       (accept),
  .armed        (armed),
  .opcode_phase (opcode_phase),
  .do_fill      (do_fill),
  .op_units     (op_units)
);

// File: tb/spi_dummy_snooper_test.sv
module spi_dummy_snooper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int SCALE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_sel = 1'b0, cs_rel = 1'b0, addr4 = 1'b0, wr_valid = 1'b0;
  logic [7:0]    dummy_val = 8'h00;
  logic [8*NB-1:0] wr_data = '0;
  logic [1:0]    wr_size = '0;
  logic          wr_ready, spi_cs_n, spi_valid;
  logic [7:0]    spi_byte;

  spi_dummy_snooper #(.MAX_WR_BYTES(NB), .DUMMY_SCALE(SCALE)) uut (
    .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .cs_rel(cs_rel), .addr4(addr4),
    .dummy_val(dummy_val), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_size(wr_size), .spi_cs_n(spi_cs_n),
    .spi_valid(spi_valid), .spi_byte(spi_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] cap [0:255];
  logic [7:0] expb [0:255];
  int cap_n = 0, exp_n = 0;

  always @(negedge clk) begin
    if (rst_n && spi_valid) begin
      if (cap_n < 256) cap[cap_n] = spi_byte;
      cap_n++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Dummy units restated from the requirement tables
  function automatic int ref_units(input logic [7:0] op);
    if (op == 8'hEB || op == 8'hEC) return 4;
    if (op == 8'hBB || op == 8'hBC || op == 8'h0C) return 2;
    if (op == 8'h0B || op == 8'h3B || op == 8'h6B || op == 8'h3C || op == 8'h6C) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] op_at(input int i);
    case (i)
      0: return 8'h03;  1: return 8'h02;  2: return 8'hA2;  3: return 8'h32;
      4: return 8'h13;  5: return 8'h12;  6: return 8'h34;  7: return 8'h0B;
      8: return 8'h3B;  9: return 8'h6B; 10: return 8'h3C; 11: return 8'h6C;
      12: return 8'hBB; 13: return 8'h0C; 14: return 8'hBC; 15: return 8'hEB;
      16: return 8'hEC; default: return 8'h9F;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic scn_begin();
    cap_n = 0; exp_n = 0;
  endtask

  task automatic push(input logic [7:0] b);
    expb[exp_n] = b; exp_n++;
  endtask

  task automatic push_data(input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) push(d[8*i +: 8]);
  endtask

  task automatic push_fill(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) push(v);
  endtask

  task automatic compare(input string req);
    #1;
    check(cap_n == exp_n, req, "byte count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      check(cap[i] == expb[i], req, $sformatf("byte %0d", i), cap[i], expb[i]);
  endtask

  task automatic wait_ready();
    while (!wr_ready) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input int n);
    wait_ready();
    wr_valid = 1'b1; wr_data = d; wr_size = 2'(n - 1);
    @(negedge clk);
    wr_valid = 1'b0;
    wait_ready();
  endtask

  task automatic sel();
    wait_ready();
    cs_sel = 1'b1; @(negedge clk); cs_sel = 1'b0;
  endtask

  task automatic rel();
    wait_ready();
    cs_rel = 1'b1; @(negedge clk); cs_rel = 1'b0;
  endtask

  // R1: reset state, then an unselected write passes
  task automatic t_reset();
    check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    check(spi_valid == 1'b0, "R1", "valid after reset", spi_valid, 0);
    check(wr_ready == 1'b1, "R1", "ready after reset", wr_ready, 1);
    scn_begin();
    wr(32'h0000_00EB, 1); push(8'hEB);
    wr(32'h1122_3344, 4); push_data(32'h1122_3344, 4);
    compare("R1");
  endtask

  // R4 and R3: disarmed traffic of every size
  task automatic t_passthrough();
    scn_begin();
    for (int n = 1; n <= 4; n++) begin
      wr(32'hA1B2_C3D4 + n, n); push_data(32'hA1B2_C3D4 + n, n);
    end
    compare("R4");
  endtask

  // R5, R6, R7: each opcode through select, opcode, address, trigger
  task automatic t_opcode_sweep();
    addr4 = 1'b0; dummy_val = 8'h5A;
    for (int i = 0; i < 18; i++) begin
      logic [7:0] op;
      op = op_at(i);
      scn_begin();
      sel();
      check(spi_cs_n == 1'b0, "R2", "cs_n after select", spi_cs_n, 0);
      wr({24'h0, op}, 1); push(op);
      wr(32'h0010_2030, 3); push_data(32'h0010_2030, 3);
      wr(32'h0000_00E7, 1);
      if (ref_units(op) > 0) push_fill(ref_units(op) * SCALE, 8'h5A);
      else push(8'hE7);
      wr(32'h0000_0066, 1); push(8'h66);
      compare(ref_units(op) > 0 ? "R6" : "R5");
      rel();
      check(spi_cs_n == 1'b1, "R2", "cs_n after release", spi_cs_n, 1);
    end
  endtask

  // R8: in 4-byte mode position 4 still forwards, position 5 fills
  task automatic t_wide_addr();
    addr4 = 1'b1; dummy_val = 8'h81;
    scn_begin();
    sel();
    wr(32'h0000_000C, 1); push(8'h0C);
    wr(32'h00AA_BBCC, 3); push_data(32'h00AA_BBCC, 3);
    wr(32'h0000_00DD, 1); push(8'hDD);
    wr(32'h0000_0099, 1); push_fill(2 * SCALE, 8'h81);
    compare("R8");
    rel();
    addr4 = 1'b0;
  endtask

  // R7: opcode written inside a wider write counts its full size
  task automatic t_wide_opcode_write();
    dummy_val = 8'h17;
    scn_begin();
    sel();
    wr(32'h0000_116B, 2); push_data(32'h0000_116B, 2);
    wr(32'h0000_2233, 2); push_data(32'h0000_2233, 2);
    wr(32'hDEAD_BEEF, 4); push_fill(SCALE, 8'h17);
    wr(32'h0000_0042, 1); push(8'h42);
    compare("R7");
    rel();
  endtask

  // R2: release mid-command discards pending count; reselect starts clean
  task automatic t_release_mid();
    dummy_val = 8'h3E;
    scn_begin();
    sel();
    wr(32'h0000_00BB, 1); push(8'hBB);
    wr(32'h0000_0102, 2); push_data(32'h0000_0102, 2);
    rel();
    check(spi_cs_n == 1'b1, "R2", "cs_n after mid release", spi_cs_n, 1);
    wr(32'h0000_0044, 1); push(8'h44);
    wr(32'h0000_0045, 1); push(8'h45);
    sel();
    wr(32'h0000_0003, 1); push(8'h03);
    wr(32'h0004_0506, 3); push_data(32'h0004_0506, 3);
    wr(32'h0000_0047, 1); push(8'h47);
    compare("R2");
    rel();
    // both pulses together: release wins
    cs_sel = 1'b1; cs_rel = 1'b1; @(negedge clk); cs_sel = 1'b0; cs_rel = 1'b0;
    check(spi_cs_n == 1'b1, "R2", "cs_n with both pulses", spi_cs_n, 1);
  endtask

  // R10 and R3: select/release pulses during a byte run are ignored
  task automatic t_busy_cs();
    dummy_val = 8'hC9;
    scn_begin();
    sel();
    wr(32'h0000_000B, 1); push(8'h0B);
    wait_ready();
    wr_valid = 1'b1; wr_data = 32'h0708_090A; wr_size = 2'd3;
    @(negedge clk);
    wr_valid = 1'b0;
    cs_rel = 1'b1;
    #1;
    check(wr_ready == 1'b0, "R3", "ready while sending", wr_ready, 0);
    @(negedge clk);
    cs_rel = 1'b0;
    check(spi_cs_n == 1'b0, "R10", "cs_n after busy release", spi_cs_n, 0);
    wait_ready();
    push_data(32'h0708_090A, 4);
    wr(32'h0000_00F0, 1); push_fill(SCALE, 8'hC9);
    compare("R10");
    rel();
  endtask

  // R9: fill byte captured at acceptance
  task automatic t_fill_hold();
    dummy_val = 8'h3C;
    scn_begin();
    sel();
    wr(32'h0000_00EB, 1); push(8'hEB);
    wr(32'h0001_0203, 3); push_data(32'h0001_0203, 3);
    wait_ready();
    wr_valid = 1'b1; wr_data = 32'h0000_0000; wr_size = 2'd0;
    @(negedge clk);
    wr_valid = 1'b0;
    dummy_val = 8'hC3;
    wait_ready();
    push_fill(4 * SCALE, 8'h3C);
    compare("R9");
    rel();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_opcode_sweep();
    t_wide_addr();
    t_wide_opcode_write();
    t_release_mid();
    t_busy_cs();
    t_fill_hold();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule